// File: doc/BRIEF.md
# Per-Flow Cell Routing Lookup

This block chooses the output port for each cell that enters a four-port cell switch. Every ingress port gives the block the first header word of its cell and a one-cycle strobe. The block takes the virtual path identifier and the virtual circuit identifier from that word. It then reads two tables that a control processor keeps up to date:

- a path table, indexed by the path identifier, for aggregate traffic;
- a circuit table, indexed by the low bits of the circuit identifier, for individual flows.

Each table entry has a valid bit and one 2-bit destination per ingress port. The same identifier can therefore be steered differently depending on the port where it arrives. This allows a flow to be sent through a processing module and then on to the switch or the line card, to be chained through both modules, or to be looped back for test.

Priority runs from the circuit table, to the path table, to a fixed bypass. The bypass sends cells from the switch side to the line card and cells from the line card to the switch. The result is registered and appears one cycle after the strobe, before the first payload word leaves. A write port updates one entry per cycle. Other flows carry on while an entry is rewritten.

Top module: `vc_route_lookup`

## Requirements
- R1: For every port p, `out_valid[p]` is high in exactly the cycle after `hdr_valid[p]` was sampled high. While no lookup is returned, `out_dst[p]` holds its last value.
- R2: Reset is synchronous and active high. It clears the valid bits of both tables and drives every `out_valid` low.
- R3: The header word carries the path identifier in bits [31:22] and the circuit identifier in bits [21:6]. The circuit table is indexed by circuit bits [15:10] being ignored, that is by the low 10 circuit bits (word bits [15:6]). Word bits [5:0] are ignored.
- R4: A valid circuit entry wins. The destination is the entry's field for the ingress port p, at bits [2p+1:2p] of the entry.
- R5: If the circuit entry is not valid and the path entry is valid, the destination is the path entry's field for port p, at the same bit positions.
- R6: If neither entry is valid, the bypass applies. Destinations are encoded 0 = switch, 1 = line card, 2 = module A, 3 = module B, and ingress ports are numbered with the same codes. Ports 0 and 2 go to 1 (line card), and ports 1 and 3 go to 0 (switch).
- R7: A write with `wr_table` = 0 updates the path table and a write with `wr_table` = 1 updates the circuit table. A lookup sampled in the same cycle as a write to the entry it reads gets the old contents. Later lookups get the new contents.
- R8: A write with `wr_valid` = 0 invalidates the entry, so lookups fall back to the next rule.
- R9: All four ports look up independently in the same cycle.
- R10: A write changes only the addressed entry of the selected table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 4 | Per-port strobe marking a header word |
| hdr_word | input | 4x32 | Per-port first header word |
| wr_en | input | 1 | Table write strobe |
| wr_table | input | 1 | 0 = path table, 1 = circuit table |
| wr_idx | input | 10 | Entry index to write |
| wr_valid | input | 1 | Valid bit written to the entry |
| wr_dst | input | 8 | Four 2-bit destinations, port p at bits [2p+1:2p] |
| out_valid | output | 4 | Per-port result strobe |
| out_dst | output | 4x2 | Per-port destination code |

## Verification
The assertions assume that `hdr_valid` and the write inputs change only between clock edges. They also assume that the two table outputs for a port come from the same header word. The stimulus meets this by driving every input on the falling edge and releasing it one falling edge later. A header strobe lasts exactly one cycle, and writes and lookups never overlap, except in the single collision case that is set up on purpose. Results are sampled on the falling edge that follows the capturing rising edge.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
    localparam int HDR_W   = 32;
    localparam int VPI_LSB = 22;
    localparam int VCI_LSB = 6;
    localparam int VCI_W   = 16;

    typedef enum logic [1:0] {
        DST_SWITCH = 2'd0,
        DST_LINE   = 2'd1,
        DST_MODA   = 2'd2,
        DST_MODB   = 2'd3
    } dst_e;

    // Bypass: even ports (switch, module A) go to the line card, odd ports go to the switch.
    function automatic logic [1:0] bypass_dst(input int port);
        return (port % 2 == 0) ? DST_LINE : DST_SWITCH;
    endfunction
endpackage

// File: rtl/vcr_table.sv
module vcr_table #(
    parameter int NPORT = 4,
    parameter int IDX_W = 10,
    parameter int DST_W = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic                              wr_valid,
    input  logic [NPORT*DST_W-1:0]            wr_dst,
    input  logic [NPORT-1:0][IDX_W-1:0]       rd_idx,
    output logic [NPORT-1:0]                  rd_hit,
    output logic [NPORT-1:0][DST_W-1:0]       rd_dst
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int ENT_W = NPORT * DST_W;

    logic [ENT_W-1:0] dst_mem [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst)
            vld_q <= '0;
        else if (wr_en)
            vld_q[wr_idx] <= wr_valid;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            dst_mem[wr_idx] <= wr_dst;
    end

    // Reads are combinational and see the contents from before this cycle's write.
    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        logic [ENT_W-1:0] ent;
        assign ent       = dst_mem[rd_idx[p]];
        assign rd_hit[p] = vld_q[rd_idx[p]];
        assign rd_dst[p] = ent[p*DST_W +: DST_W];
    end
endmodule

// File: rtl/vcr_select.sv
module vcr_select #(
    parameter int PORT_ID = 0,
    parameter int DST_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             vc_hit,
    input  logic [DST_W-1:0] vc_dst,
    input  logic             vp_hit,
    input  logic [DST_W-1:0] vp_dst,
    output logic             res_valid,
    output logic [DST_W-1:0] res_dst
);
    logic [DST_W-1:0] pick;

    always_comb begin
        if (vc_hit)      pick = vc_dst;
        else if (vp_hit) pick = vp_dst;
        else             pick = DST_W'(vcr_pkg::bypass_dst(PORT_ID));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_dst   <= '0;
        end else begin
            res_valid <= req;
            if (req) res_dst <= pick;
        end
    end
endmodule

// File: rtl/vc_route_lookup.sv
module vc_route_lookup #(
    parameter int NPORT = 4,
    parameter int IDX_W = 10,
    parameter int DST_W = 2
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NPORT-1:0]                      hdr_valid,
    input  logic [NPORT-1:0][vcr_pkg::HDR_W-1:0]  hdr_word,
    input  logic                                  wr_en,
    input  logic                                  wr_table,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic                                  wr_valid,
    input  logic [NPORT*DST_W-1:0]                wr_dst,
    output logic [NPORT-1:0]                      out_valid,
    output logic [NPORT-1:0][DST_W-1:0]           out_dst
);
    import vcr_pkg::*;

    logic [NPORT-1:0][IDX_W-1:0] vp_idx, vc_idx;
    logic [NPORT-1:0]            vp_hit, vc_hit;
    logic [NPORT-1:0][DST_W-1:0] vp_dst, vc_dst;
    logic [NPORT-1:0]            hdr_unused;

    for (genvar p = 0; p < NPORT; p++) begin : g_parse
        assign vp_idx[p] = hdr_word[p][VPI_LSB +: IDX_W];
        assign vc_idx[p] = hdr_word[p][VCI_LSB +: IDX_W];
        assign hdr_unused[p] = ^{hdr_word[p][VCI_LSB+IDX_W +: VCI_W-IDX_W],
                                 hdr_word[p][VCI_LSB-1:0]};
    end

    vcr_table #(.NPORT(NPORT), .IDX_W(IDX_W), .DST_W(DST_W)) u_path (
        .clk(clk), .rst(rst),
        .wr_en(wr_en && !wr_table), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_dst(wr_dst),
        .rd_idx(vp_idx), .rd_hit(vp_hit), .rd_dst(vp_dst)
    );

    vcr_table #(.NPORT(NPORT), .IDX_W(IDX_W), .DST_W(DST_W)) u_circ (
        .clk(clk), .rst(rst),
        .wr_en(wr_en && wr_table), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_dst(wr_dst),
        .rd_idx(vc_idx), .rd_hit(vc_hit), .rd_dst(vc_dst)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        vcr_select #(.PORT_ID(p), .DST_W(DST_W)) u_sel (
            .clk(clk), .rst(rst), .req(hdr_valid[p]),
            .vc_hit(vc_hit[p]), .vc_dst(vc_dst[p]),
            .vp_hit(vp_hit[p]), .vp_dst(vp_dst[p]),
            .res_valid(out_valid[p]), .res_dst(out_dst[p])
        );

        // R1
        a_r1_result_follows: assert property (@(posedge clk) disable iff (rst)
            hdr_valid[p] |=> out_valid[p]);
        a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
            !hdr_valid[p] |=> !out_valid[p]);
        a_r1_hold_dst: assert property (@(posedge clk) disable iff (rst)
            !hdr_valid[p] |=> $stable(out_dst[p]));
        // R4
        a_r4_circuit_wins: assert property (@(posedge clk) disable iff (rst)
            (hdr_valid[p] && vc_hit[p]) |=> out_dst[p] == $past(vc_dst[p]));
        // R5
        a_r5_path_fallback: assert property (@(posedge clk) disable iff (rst)
            (hdr_valid[p] && !vc_hit[p] && vp_hit[p]) |=> out_dst[p] == $past(vp_dst[p]));
        // R6
        a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
            (hdr_valid[p] && !vc_hit[p] && !vp_hit[p]) |=>
                out_dst[p] == DST_W'(bypass_dst(p)));
    end
endmodule

// File: tb/vc_route_lookup_test.sv
module vc_route_lookup_test;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       hdr_valid = '0;
    logic [3:0][31:0] hdr_word = '0;
    logic             wr_en = 1'b0, wr_table = 1'b0, wr_valid = 1'b0;
    logic [9:0]       wr_idx = '0;
    logic [7:0]       wr_dst = '0;
    logic [3:0]       out_valid;
    logic [3:0][1:0]  out_dst;

    int checks = 0;
    int failures = 0;

    vc_route_lookup uut (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
        .wr_en(wr_en), .wr_table(wr_table), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_dst(wr_dst), .out_valid(out_valid), .out_dst(out_dst)
    );

    always #5 clk = ~clk;

    // vector: {port[29:28], vpi[27:18], vci[17:2], expected dst[1:0]}
    localparam logic [29:0] VEC [9] = '{
        {2'd0, 10'd5, 16'd7,      2'd3},  // R4 circuit wins, port 0
        {2'd2, 10'd5, 16'd7,      2'd1},  // R4 port 2 field
        {2'd1, 10'd5, 16'd100,    2'd1},  // R5 path fallback
        {2'd3, 10'd5, 16'd9,      2'd3},  // R8 invalidated circuit -> path
        {2'd3, 10'd6, 16'd9,      2'd0},  // R6 bypass port 3
        {2'd2, 10'd0, 16'd7,      2'd1},  // R4 circuit without path
        {2'd0, 10'd5, 16'h0407,   2'd3},  // R3 upper circuit bits ignored
        {2'd1, 10'd6, 16'd100,    2'd0},  // R6 bypass port 1
        {2'd0, 10'd5, 16'd100,    2'd0}   // R5 path field port 0
    };

    function automatic logic [31:0] mk_hdr(input logic [9:0] vpi, input logic [15:0] vci);
        return {vpi, vci, 6'h2a};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write(input bit tbl, input int idx, input bit v, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_table = tbl; wr_idx = 10'(idx); wr_valid = v; wr_dst = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup1(input int port, input logic [9:0] vpi, input logic [15:0] vci,
                           input int exp, input string tag);
        @(negedge clk);
        hdr_valid = '0;
        hdr_valid[port] = 1'b1;
        hdr_word[port] = mk_hdr(vpi, vci);
        @(negedge clk);
        hdr_valid = '0;
        check(out_valid == 4'(1 << port), {tag, " valid"}, int'(out_valid), 1 << port);
        check(out_dst[port] == 2'(exp), tag, int'(out_dst[port]), exp);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_valid == 4'b0, "R2 reset valid", int'(out_valid), 0);

        // R6 bypass on empty tables, all ports at once (R9)
        @(negedge clk);
        hdr_valid = 4'hf;
        for (int p = 0; p < 4; p++) hdr_word[p] = mk_hdr(10'd5, 16'd7);
        @(negedge clk);
        hdr_valid = '0;
        check(out_valid == 4'hf, "R6 bypass valid", int'(out_valid), 15);
        for (int p = 0; p < 4; p++)
            check(out_dst[p] == ((p % 2 == 0) ? 2'd1 : 2'd0), "R6 bypass",
                  int'(out_dst[p]), (p % 2 == 0) ? 1 : 0);

        write(1'b0, 5, 1'b1, 8'he4);   // path 5: p0=0 p1=1 p2=2 p3=3
        write(1'b1, 7, 1'b1, 8'h1b);   // circuit 7: p0=3 p1=2 p2=1 p3=0
        write(1'b1, 9, 1'b1, 8'h55);
        write(1'b1, 9, 1'b0, 8'hff);   // R8 invalidate

        for (int i = 0; i < 9; i++)
            lookup1(int'(VEC[i][29:28]), VEC[i][27:18], VEC[i][17:2], int'(VEC[i][1:0]),
                    $sformatf("R4/R5/R6/R3/R8 vec%0d", i));

        // R9 all four ports simultaneously on circuit 7
        @(negedge clk);
        hdr_valid = 4'hf;
        for (int p = 0; p < 4; p++) hdr_word[p] = mk_hdr(10'd5, 16'd7);
        @(negedge clk);
        hdr_valid = '0;
        for (int p = 0; p < 4; p++)
            check(out_dst[p] == 2'(3 - p), "R9 parallel", int'(out_dst[p]), 3 - p);

        // R1 idle cycle: no valid, destination held
        @(negedge clk);
        check(out_valid == 4'b0, "R1 idle valid", int'(out_valid), 0);
        check(out_dst[0] == 2'd3, "R1 hold dst", int'(out_dst[0]), 3);

        // R7 collision: write circuit 11 in the same cycle as a lookup of it
        @(negedge clk);
        hdr_valid = 4'b0001;
        hdr_word[0] = mk_hdr(10'd5, 16'd11);
        wr_en = 1'b1; wr_table = 1'b1; wr_idx = 10'd11; wr_valid = 1'b1; wr_dst = 8'h02;
        @(negedge clk);
        hdr_valid = '0; wr_en = 1'b0;
        check(out_dst[0] == 2'd0, "R7 collision old", int'(out_dst[0]), 0);
        lookup1(0, 10'd5, 16'd11, 2, "R7 new data");

        // R10 the other entries are unchanged
        lookup1(0, 10'd5, 16'd7, 3, "R10 circuit 7 intact");
        lookup1(1, 10'd5, 16'd200, 1, "R10 path 5 intact");
        write(1'b0, 6, 1'b1, 8'hff);
        lookup1(3, 10'd6, 16'd7, 0, "R10 path write vs circuit");

        // R2 reset clears the tables
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 4'b0, "R2 reset valid again", int'(out_valid), 0);
        lookup1(0, 10'd5, 16'd7, 1, "R2 entries cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule